// File: doc/BRIEF.md
# Unaligned Vector Load Merge Unit

This unit carries out a single vector register load from an arbitrary byte address. A caller hands over the start address, an encoding mode, and the 4-bit extra-register-select field from the instruction. The unit then fetches naturally aligned 32-byte beats from a simple memory port. It needs one beat when the requested bytes fit inside one aligned chunk, and two beats when they cross into the next chunk. It shifts the concatenated beats so that the byte at the start address lands at bit 0, and reports a 256-bit result together with a byte-write mask for a 256-bit destination register.

The load width follows from the mode. Mode 2'b00 is the legacy 128-bit form, 2'b01 is the vector-extension 128-bit form, and 2'b10 is the vector-extension 256-bit form. Mode 2'b11 is reserved. How the upper destination half is treated also depends on the mode: the legacy form leaves it untouched through the mask, the vector-extension 128-bit form writes zeros there, and the 256-bit form fills it with loaded data. A vector-extension load whose select field is not 4'b1111 ends with an invalid-opcode fault and never touches memory.

Only one load is in flight at a time. The memory response may stall for any number of cycles.

Top module: `uvload_merge`

## Requirements
- R1: `req_ready` is high only while the unit is idle. After a request is accepted, `req_ready` stays low until the cycle after `done`, and it is never high while `mem_req_valid` is high.
- R2: A non-faulting load issues two memory reads when (address mod 32) + width > 32, and one read otherwise. The width is 16 bytes for modes 2'b00 and 2'b01 and 32 bytes for mode 2'b10. No alignment fault is ever raised.
- R3: The first read address is the start address with its low 5 bits cleared. The second read is at that address plus 32. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`.
- R4: Byte i of `res_data` (bits 8i+7:8i) equals memory byte (address + i) for every i below the load width. Beat byte j sits at `mem_rsp_data` bits 8j+7:8j.
- R5: In mode 2'b00, `res_wmask` is 32'h0000FFFF, so bytes 15:0 are written and destination bits 255:128 keep their old value. `res_data` bits 255:128 are zero.
- R6: In mode 2'b01, `res_wmask` is all ones and `res_data` bits 255:128 are zero, which clears the upper destination half.
- R7: In mode 2'b10, `res_wmask` is all ones and all 256 bits carry loaded data.
- R8: A fault occurs in mode 2'b11, or in mode 2'b01 or 2'b10 with `req_xsel` ≠ 4'b1111. It gives `done` with `fault` high, `res_wmask` zero and `res_data` zero, and issues no memory read. In mode 2'b00, `req_xsel` is ignored.
- R9: `done` is a one-cycle pulse. For a non-faulting load it comes only after the response to the last needed read, however long the responses stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_addr | input | AW | Start byte address |
| req_mode | input | 2 | 00 legacy 128, 01 extension 128, 10 extension 256, 11 reserved |
| req_xsel | input | 4 | Extra-register-select field; must be 4'b1111 in extension modes |
| mem_req_valid | output | 1 | Aligned read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | 32-byte aligned read address |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_data | input | 256 | Returned beat, little-endian |
| done | output | 1 | Result valid for one cycle |
| res_data | output | 256 | Extracted load data |
| res_wmask | output | 32 | Byte write enables for the destination |
| fault | output | 1 | Invalid-opcode fault, valid with done |

## Verification
Directed loads sit at offsets 0, 1, 15, 16, 17 and 31 within a 32-byte chunk, across all three data modes. These positions separate the one-beat and two-beat paths right at the boundary where the sum of offset and width passes 32, and they expose a wrong shift amount or a swapped beat order. Fault cases cover the reserved mode, a bad select field in each extension mode, and a legacy load carrying a bad field. The first three must not reach memory, while the legacy load must complete normally. Random addresses, modes and select values then run against random memory stalls and ready gaps. A bench-side destination register, updated through the mask, shows whether the upper half was kept, cleared or overwritten.

// File: rtl/uvload_merge.sv
module uvload_merge #(
  parameter int AW = 32,
  parameter logic [3:0] XSEL_OK = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_mode,
  input  logic [3:0]    req_xsel,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [255:0]  mem_rsp_data,
  output logic          done,
  output logic [255:0]  res_data,
  output logic [31:0]   res_wmask,
  output logic          fault
);
  localparam int BB = 32;
  localparam int OW = $clog2(BB);
  localparam logic [1:0] M_LEG = 2'b00, M_X128 = 2'b01, M_X256 = 2'b10, M_RSV = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] base_q;
  logic [OW-1:0] off_q;
  logic [1:0]    mode_q;
  logic          two_q, beat_q, flt_q;
  logic [255:0]  lo_q, hi_q;

  logic          acc, bad, two;
  logic [OW:0]   span;
  logic [511:0]  sh;

  assign acc  = req_valid && req_ready;
  assign bad  = (req_mode == M_RSV) || (req_mode != M_LEG && req_xsel != XSEL_OK);
  assign span = {1'b0, req_addr[OW-1:0]} + ((req_mode == M_X256) ? (OW+1)'(BB) : (OW+1)'(BB/2));
  assign two  = span > (OW+1)'(BB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      off_q  <= '0;
      mode_q <= M_LEG;
      two_q  <= 1'b0;
      beat_q <= 1'b0;
      flt_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc) begin
          mode_q <= req_mode;
          off_q  <= req_addr[OW-1:0];
          base_q <= {req_addr[AW-1:OW], {OW{1'b0}}};
          two_q  <= two;
          beat_q <= 1'b0;
          flt_q  <= bad;
          st     <= bad ? S_FIN : S_REQ;
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (beat_q) hi_q <= mem_rsp_data;
          else        lo_q <= mem_rsp_data;
          if (two_q && !beat_q) begin
            beat_q <= 1'b1;
            st     <= S_REQ;
          end else begin
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = base_q + (beat_q ? AW'(BB) : AW'(0));

  assign sh = {hi_q, lo_q} >> {off_q, 3'b000};

  assign done      = (st == S_FIN);
  assign fault     = done && flt_q;
  assign res_data  = flt_q ? '0 :
                     (mode_q == M_X256) ? sh[255:0] : {128'b0, sh[127:0]};
  assign res_wmask = flt_q ? '0 :
                     (mode_q == M_LEG) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
endmodule

module uvload_merge_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          done,
  input logic          fault,
  input logic [31:0]   res_wmask,
  input logic [255:0]  res_data
);
  // R1
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R1
  busy_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R3
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[4:0] == 5'd0));
  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R8
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (res_wmask == 32'd0 && res_data == 256'd0));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind uvload_merge uvload_merge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .fault(fault),
  .res_wmask(res_wmask), .res_data(res_data)
);

// File: tb/tb_uvload_merge.sv
module tb_uvload_merge;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_mode = '0;
  logic [3:0]   req_xsel = '0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [255:0] mem_rsp_data = '0;
  logic         done;
  logic [255:0] res_data;
  logic [31:0]  res_wmask;
  logic         fault;

  int unsigned nvec = 0, nbad = 0, cyc = 0;
  int          nreq = 0;
  logic [31:0] raddr [2];
  bit          pend = 0;
  int          dly = 0;
  logic [31:0] paddr = '0;
  logic [255:0] dst = '0;
  int unsigned seed0;

  always #4 clk = ~clk;

  uvload_merge dut (.*);

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'h1d) ^ a[15:8] ^ (a[23:16] + 8'h5a) ^ a[31:24];
  endfunction

  function automatic logic [255:0] beat(input logic [31:0] a);
    logic [255:0] v;
    for (int j = 0; j < 32; j++) v[8*j +: 8] = mb(a + 32'(j));
    return v;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = beat(paddr);
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        pend  = 1;
        paddr = mem_req_addr;
        dly   = $urandom % 6;
        if (nreq < 2) raddr[nreq] = mem_req_addr;
        nreq++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
      end
    end
  end

  task automatic do_load(input logic [31:0] a, input logic [1:0] m, input logic [3:0] x);
    int w, off, nexp, g;
    bit flt;
    logic [255:0] ed, old, edst;
    logic [31:0] em;
    w    = (m == 2'b10) ? 32 : 16;
    off  = int'(a[4:0]);
    flt  = (m == 2'b11) || (m != 2'b00 && x != 4'hF);
    nexp = flt ? 0 : ((off + w > 32) ? 2 : 1);
    ed   = '0;
    if (!flt) for (int i = 0; i < w; i++) ed[8*i +: 8] = mb(a + 32'(i));
    em   = flt ? 32'd0 : (m == 2'b00) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    old  = dst;
    if (flt) edst = old;
    else if (m == 2'b00) edst = {old[255:128], ed[127:0]};
    else edst = ed;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mode = m; req_xsel = x;
    nreq = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_xsel  = 4'($urandom);
    req_mode  = 2'($urandom);
    chk(!req_ready, "R1 ready low after accept", 256'(req_ready), 256'(0));
    g = 0;
    while (!done && g < 200) begin @(negedge clk); g++; end
    chk(done, "R9 done reached", 256'(done), 256'(1));
    chk(fault == flt, "R8 fault flag", 256'(fault), 256'(flt));
    chk(nreq == nexp, "R2 read count", 256'(nreq), 256'(nexp));
    chk(!pend, "R9 done after last response", 256'(pend), 256'(0));
    if (nexp >= 1)
      chk(raddr[0] == {a[31:5], 5'd0}, "R3 first read addr", 256'(raddr[0]), 256'({a[31:5], 5'd0}));
    if (nexp == 2)
      chk(raddr[1] == {a[31:5], 5'd0} + 32'd32, "R3 second read addr", 256'(raddr[1]), 256'({a[31:5], 5'd0} + 32'd32));
    if (flt) chk(res_data == ed, "R8 fault data", res_data, ed);
    else if (m == 2'b00) chk(res_data == ed, "R4 R5 legacy data", res_data, ed);
    else if (m == 2'b01) chk(res_data == ed, "R4 R6 x128 data", res_data, ed);
    else chk(res_data == ed, "R4 R7 x256 data", res_data, ed);
    chk(res_wmask == em, "R5 R6 R7 R8 write mask", 256'(res_wmask), 256'(em));
    for (int b = 0; b < 32; b++) if (res_wmask[b]) dst[8*b +: 8] = res_data[8*b +: 8];
    chk(dst == edst, "R5 R6 R7 destination merge", dst, edst);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 256'(done), 256'(0));
  endtask

  initial begin
    seed0 = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    chk(!done && !mem_req_valid, "R1 reset outputs quiet", 256'({done, mem_req_valid}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 idle ready", 256'(req_ready), 256'(1));
    dst = {8{32'hC0FF_EE11}};
    do_load(32'h0000_1000, 2'b10, 4'hF);
    do_load(32'h0000_1001, 2'b10, 4'hF);
    do_load(32'h0000_2010, 2'b00, 4'h0);
    do_load(32'h0000_2011, 2'b00, 4'hF);
    do_load(32'h0000_300F, 2'b01, 4'hF);
    do_load(32'h0000_301F, 2'b01, 4'hF);
    do_load(32'h0000_3010, 2'b01, 4'hF);
    do_load(32'h0000_3011, 2'b01, 4'hF);
    do_load(32'hFFFF_FFF0, 2'b10, 4'hF);
    do_load(32'h0000_4003, 2'b01, 4'hE);
    do_load(32'h0000_4003, 2'b10, 4'h7);
    do_load(32'h0000_4003, 2'b11, 4'hF);
    do_load(32'h0000_501F, 2'b00, 4'h3);
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      logic [3:0] x;
      m = 2'($urandom);
      x = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      do_load($urandom, m, x);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule